// File: doc/BRIEF.md
# Prioritized Sixteen-Input Interrupt Controller

This block collects requests from sixteen interrupt sources, remembers each one as a pending flag, and presents one of them to a processor. Each source has a 4-bit priority. Value zero masks the source, 1 is the lowest enabled level and 15 the highest. The controller offers the processor the best enabled pending source, together with its index. The processor takes the request by pulsing an acknowledge. That acknowledge clears the flag and records the level as in service.

The controller keeps track of the levels currently in service. A new request interrupts ongoing service only when its priority is strictly higher than the highest level in service. Software ends a service by writing to the return register, which releases the most recent (highest) level. A byte-wide register port holds the priorities, gives the pending flags back to software and sets the service mode. Besides normal operation there is a mode that serves a single request and then stops. Another mode holds the request line low until software changes the mode again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, all priority fields, pending flags and the mode field read 0. No level is in service and `irq_o` is low.
- R2: Register addresses 0 to 7 each hold two priority fields and read back what was written. Address k holds the field of input 2k in bits [3:0] and the field of input 2k+1 in bits [7:4].
- R3: A rising edge on `req_in[i]` sets pending flag i, whatever its priority, including priority 0. A level held high sets the flag only once.
- R4: A source whose priority is 0 is never presented on `irq_o`/`irq_vec`.
- R5: Among the enabled pending sources, the highest priority wins. When priorities are equal, the higher-numbered input wins.
- R6: `irq_o` is high, and `irq_vec` carries the winner's index, exactly when the winner's priority is strictly greater than the current level. The current level is the highest level in service, or 0 when none is in service. `irq_o` is high only when the mode allows it.
- R7: An `irq_ack` pulse while `irq_o` is high clears the presented source's pending flag and puts its priority in service. An `irq_ack` while `irq_o` is low changes nothing.
- R8: If a new rising edge arrives on the presented input in the same cycle as its acknowledge, its pending flag stays set.
- R9: Reading address 8 returns pending flags 7..0, and reading address 9 returns flags 15..8. Any write to address 8 releases the highest level in service.
- R10: Address 10 bits [1:0] hold the mode. The value 00 is normal operation. The value 01 is single service: after one write to address 8, `irq_o` stays low until address 10 is written again. The values 10 and 11 hold `irq_o` low, and writes to address 8 still release levels.
- R11: A return write and an acknowledge in the same cycle release the old top level and put the newly acknowledged level in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 16 | Interrupt request lines, captured on rising edges |
| irq_ack | input | 1 | Processor takes the presented request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec | output | 4 | Index of the presented input |

## Verification
Two collisions are provoked on purpose. The first puts a new rising edge on the presented input in the very cycle it is acknowledged. The bench judges it by reading the pending flag back, which must still be set, and by seeing the request return once its level is released. The second raises a return-register write and an acknowledge in the same cycle. The bench judges it by counting how many further return writes it takes before a lower-priority request is presented again. Exactly one must be needed, which shows that the old top level left service and the new one entered.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int IRQ_N   = 16;
    localparam int PRIO_W  = 4;
    localparam int BUS_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int IDX_W   = $clog2(IRQ_N);
    localparam int NLVL    = 2 ** PRIO_W;

    // service mode field encoding
    typedef enum logic [1:0] {
        SVC_NORMAL = 2'b00,
        SVC_SINGLE = 2'b01,
        SVC_HOLD   = 2'b10,
        SVC_HOLD_B = 2'b11
    } svc_mode_e;

    // winner of the arbitration
    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } arb_res_t;

    // highest set bit of an in-service mask (0 when empty)
    function automatic logic [PRIO_W-1:0] top_level(input logic [NLVL-1:0] m);
        logic [PRIO_W-1:0] r;
        r = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (m[l]) r = PRIO_W'(l);
        end
        return r;
    endfunction

    function automatic logic mode_blocks(input svc_mode_e m, input logic halted);
        return (m == SVC_HOLD) || (m == SVC_HOLD_B) || ((m == SVC_SINGLE) && halted);
    endfunction

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N = irq_prio_pkg::IRQ_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] clr_oh,
    output logic [N-1:0] rise,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] prev_q;

    assign rise = req_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= req_in;
            // a fresh edge wins over the clear of the same flag
            pend_q <= (pend_q & ~clr_oh) | rise;
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_prio_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int PW = PRIO_W
) (
    input  logic [N-1:0]    pend,
    input  logic [N*PW-1:0] prio_flat,
    output arb_res_t        res
);
    always_comb begin
        res = '0;
        for (int i = 0; i < N; i++) begin
            // ">=" while walking upward lets the higher index take ties
            if (pend[i] && (prio_flat[i*PW +: PW] != '0) &&
                (!res.valid || (prio_flat[i*PW +: PW] >= res.prio))) begin
                res.valid = 1'b1;
                res.prio  = prio_flat[i*PW +: PW];
                res.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack
    import irq_prio_pkg::*;
#(
    parameter int PW = PRIO_W,
    localparam int NL = 2 ** PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [PW-1:0] push_lvl,
    input  logic          pop,
    output logic [PW-1:0] cur_lvl,
    output logic [NL-1:0] in_svc
);
    logic [NL-1:0] top_oh;
    logic [NL-1:0] push_oh;

    // levels in service strictly increase, so a mask is the whole stack
    assign cur_lvl = top_level(in_svc);
    assign top_oh  = (pop && (in_svc != '0)) ? (NL'(1) << cur_lvl) : '0;
    assign push_oh = push ? (NL'(1) << push_lvl) : '0;

    always_ff @(posedge clk) begin
        if (rst) in_svc <= '0;
        else     in_svc <= (in_svc & ~top_oh) | push_oh;
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_prio_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int PW = PRIO_W,
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [N-1:0]    pend,
    output logic [N*PW-1:0] prio_flat,
    output svc_mode_e       mode,
    output logic            halted,
    output logic            ret_wr,
    output logic [DW-1:0]   rdata
);
    localparam int FPR    = DW / PW;
    localparam int NREG   = N / FPR;
    localparam int A_RET  = NREG;
    localparam int A_PHI  = NREG + 1;
    localparam int A_MODE = NREG + 2;

    logic [PW-1:0] prio_q [N];
    logic          mode_wr;

    assign ret_wr  = wr_en && (addr == AW'(A_RET));
    assign mode_wr = wr_en && (addr == AW'(A_MODE));

    for (genvar g = 0; g < N; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= '0;
            else if (wr_en && (addr == AW'(g / FPR)))
                prio_q[g] <= wdata[(g % FPR)*PW +: PW];
        end
        assign prio_flat[g*PW +: PW] = prio_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= SVC_NORMAL;
            halted <= 1'b0;
        end else if (mode_wr) begin
            mode   <= svc_mode_e'(wdata[1:0]);
            halted <= 1'b0;
        end else if (ret_wr && (mode == SVC_SINGLE)) begin
            halted <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == AW'(i / FPR)) rdata[(i % FPR)*PW +: PW] = prio_q[i];
        end
        if (addr == AW'(A_RET))  rdata = pend[DW-1:0];
        if (addr == AW'(A_PHI))  rdata = pend[2*DW-1:DW];
        if (addr == AW'(A_MODE)) rdata = {{(DW-2){1'b0}}, mode};
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int PW = PRIO_W,
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W,
    localparam int IW = $clog2(N),
    localparam int NL = 2 ** PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_in,
    input  logic          irq_ack,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic [IW-1:0] irq_vec
);
    logic [N-1:0]    req_rise;
    logic [N-1:0]    pend_q;
    logic [N-1:0]    clr_oh;
    logic [N*PW-1:0] prio_flat;
    svc_mode_e       mode;
    logic            halted;
    logic            ret_wr;
    logic [PW-1:0]   cur_lvl;
    logic [NL-1:0]   in_svc;
    arb_res_t        win;
    logic            take;

    irq_req_capture #(.N(N)) u_cap (
        .clk(clk), .rst(rst), .req_in(req_in), .clr_oh(clr_oh),
        .rise(req_rise), .pend_q(pend_q)
    );

    irq_prio_arbiter #(.N(N), .PW(PW)) u_arb (
        .pend(pend_q), .prio_flat(prio_flat), .res(win)
    );

    irq_service_stack #(.PW(PW)) u_stk (
        .clk(clk), .rst(rst), .push(take), .push_lvl(win.prio),
        .pop(ret_wr), .cur_lvl(cur_lvl), .in_svc(in_svc)
    );

    irq_cfg_regs #(.N(N), .PW(PW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .pend(pend_q), .prio_flat(prio_flat),
        .mode(mode), .halted(halted), .ret_wr(ret_wr), .rdata(bus_rdata)
    );

    assign irq_o   = win.valid && (win.prio > cur_lvl) && !mode_blocks(mode, halted);
    assign irq_vec = win.idx;
    assign take    = irq_o && irq_ack;
    assign clr_oh  = take ? (N'(1) << win.idx) : '0;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int N  = 16,
    parameter int PW = 4,
    parameter int IW = 4,
    parameter int NL = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_ack,
    input logic            irq_o,
    input logic [IW-1:0]   irq_vec,
    input logic [N-1:0]    req_rise,
    input logic [N-1:0]    pend_q,
    input logic [N*PW-1:0] prio_flat,
    input logic [PW-1:0]   cur_lvl,
    input logic [NL-1:0]   in_svc,
    input logic [1:0]      mode,
    input logic            ret_wr
);
    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (req_rise != '0) |=> ((pend_q & $past(req_rise)) == $past(req_rise))); // R3
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (prio_flat[irq_vec*PW +: PW] != '0)); // R4
    AST_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (prio_flat[irq_vec*PW +: PW] > cur_lvl)); // R6
    AST_VEC_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend_q[irq_vec]); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_o && irq_ack && !req_rise[irq_vec]) |=> !pend_q[$past(irq_vec)]); // R7
    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_o && !ret_wr) |=> $stable(in_svc)); // R7
    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (irq_o && irq_ack && req_rise[irq_vec]) |=> pend_q[$past(irq_vec)]); // R8
    AST_RET_POPS: assert property (@(posedge clk) disable iff (rst)
        (ret_wr && !(irq_o && irq_ack) && (in_svc != '0))
        |=> ($countones(in_svc) == $past($countones(in_svc)) - 1)); // R9
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        mode[1] |-> !irq_o); // R10
    AST_SWAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ret_wr && irq_o && irq_ack && (in_svc != '0))
        |=> ($countones(in_svc) == $past($countones(in_svc)))); // R11
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N), .PW(PW), .IW(IW), .NL(NL)) u_chk (
    .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_o(irq_o), .irq_vec(irq_vec),
    .req_rise(req_rise), .pend_q(pend_q), .prio_flat(prio_flat),
    .cur_lvl(cur_lvl), .in_svc(in_svc), .mode(mode), .ret_wr(ret_wr)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_in = '0;
    logic        irq_ack = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_o;
    logic [3:0]  irq_vec;

    int total = 0;
    int bad = 0;
    logic [3:0] shadow [16];

    irq_prio_ctrl u_dut (
        .clk(clk), .rst(rst), .req_in(req_in), .irq_ack(irq_ack),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_vec(irq_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; req_in = '0; irq_ack = 1'b0; bus_we = 1'b0;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic set_prio(input int i, input logic [3:0] p);
        int b;
        shadow[i] = p;
        b = i & ~1;
        wr(4'(i / 2), {shadow[b+1], shadow[b]});
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic irq_check(input bit exp_irq, input logic [3:0] exp_vec, input string tag);
        check(irq_o == exp_irq, {tag, " irq"}, irq_o, exp_irq);
        if (exp_irq) check(irq_vec == exp_vec, {tag, " vec"}, irq_vec, exp_vec);
    endtask

    task automatic pulse(input int i);
        req_in[i] = 1'b1; step();
        req_in[i] = 1'b0; step();
    endtask

    task automatic ack();
        irq_ack = 1'b1; step();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        irq_check(1'b0, 4'd0, "R1 reset");
        rd_check(4'd0, 8'h00, "R1 prio reg 0");
        rd_check(4'd7, 8'h00, "R1 prio reg 7");
        rd_check(4'd8, 8'h00, "R1 pending lo");
        rd_check(4'd9, 8'h00, "R1 pending hi");
        rd_check(4'd10, 8'h00, "R1 mode");
    endtask

    task automatic t_packing();
        do_reset();
        set_prio(6, 4'hA);
        set_prio(7, 4'h3);
        rd_check(4'd3, 8'h3A, "R2 nibble packing");
        rd_check(4'd0, 8'h00, "R2 other reg untouched");
        wr(4'd5, 8'hC5);
        rd_check(4'd5, 8'hC5, "R2 direct write readback");
    endtask

    task automatic t_masked_and_level();
        do_reset();
        pulse(3);
        rd_check(4'd8, 8'h08, "R3 masked input still pending");
        irq_check(1'b0, 4'd0, "R4 masked input silent");
        pulse(12);
        rd_check(4'd9, 8'h10, "R3 upper pending");
        irq_check(1'b0, 4'd0, "R4 masked upper silent");
        set_prio(5, 4'd2);
        req_in[5] = 1'b1;
        step(); step(); step();
        irq_check(1'b1, 4'd5, "R6 held level presented");
        ack();
        step(); step();
        rd_check(4'd8, 8'h08, "R3 held level sets once");
        irq_check(1'b0, 4'd0, "R7 after ack");
        req_in[5] = 1'b0;
        step();
    endtask

    task automatic t_tie();
        do_reset();
        set_prio(2, 4'd4);
        set_prio(9, 4'd4);
        set_prio(1, 4'd3);
        pulse(1); pulse(2); pulse(9);
        irq_check(1'b1, 4'd9, "R5 tie to higher index");
        set_prio(2, 4'd6);
        irq_check(1'b1, 4'd2, "R5 higher priority wins");
    endtask

    task automatic t_stray_ack();
        do_reset();
        set_prio(0, 4'd1);
        ack();
        irq_check(1'b0, 4'd0, "R7 stray ack no output");
        pulse(0);
        irq_check(1'b1, 4'd0, "R7 stray ack left no level");
        ack();
        rd_check(4'd8, 8'h00, "R7 ack clears flag");
        wr(4'd8, 8'h00);
        irq_check(1'b0, 4'd0, "R9 return with nothing pending");
    endtask

    task automatic t_preempt();
        do_reset();
        set_prio(1, 4'd5);
        set_prio(4, 4'd5);
        set_prio(10, 4'd7);
        pulse(1);
        irq_check(1'b1, 4'd1, "R6 first request");
        ack();
        pulse(4);
        irq_check(1'b0, 4'd0, "R6 equal level does not preempt");
        pulse(10);
        irq_check(1'b1, 4'd10, "R6 higher level preempts");
        ack();
        irq_check(1'b0, 4'd0, "R6 nested level 7");
        wr(4'd8, 8'h00);
        irq_check(1'b0, 4'd0, "R9 pop to level 5");
        wr(4'd8, 8'h00);
        irq_check(1'b1, 4'd4, "R9 pop to level 0");
    endtask

    task automatic t_single();
        do_reset();
        set_prio(3, 4'd2);
        set_prio(6, 4'd2);
        wr(4'd10, 8'h01);
        rd_check(4'd10, 8'h01, "R10 mode readback");
        pulse(3);
        irq_check(1'b1, 4'd3, "R10 single serves one");
        ack();
        wr(4'd8, 8'h00);
        pulse(6);
        irq_check(1'b0, 4'd0, "R10 single halted");
        rd_check(4'd8, 8'h40, "R10 pending kept while halted");
        wr(4'd10, 8'h01);
        irq_check(1'b1, 4'd6, "R10 mode rewrite resumes");
    endtask

    task automatic t_hold();
        do_reset();
        set_prio(7, 4'd9);
        set_prio(8, 4'd5);
        pulse(7);
        ack();
        pulse(8);
        irq_check(1'b0, 4'd0, "R6 lower than level 9");
        wr(4'd10, 8'h02);
        wr(4'd8, 8'h00);
        irq_check(1'b0, 4'd0, "R10 hold keeps line low");
        ack();
        rd_check(4'd9, 8'h01, "R10 ack ignored in hold");
        wr(4'd10, 8'h00);
        irq_check(1'b1, 4'd8, "R10 return popped during hold");
    endtask

    task automatic t_collide();
        do_reset();
        set_prio(11, 4'd6);
        pulse(11);
        irq_check(1'b1, 4'd11, "R8 presented");
        req_in[11] = 1'b1; irq_ack = 1'b1;
        step();
        req_in[11] = 1'b0; irq_ack = 1'b0;
        step();
        rd_check(4'd9, 8'h08, "R8 edge beats ack clear");
        irq_check(1'b0, 4'd0, "R8 same level in service");
        wr(4'd8, 8'h00);
        irq_check(1'b1, 4'd11, "R8 re-presented after return");
    endtask

    task automatic t_ret_ack();
        do_reset();
        set_prio(2, 4'd3);
        set_prio(13, 4'd8);
        pulse(2);
        ack();
        pulse(13);
        irq_check(1'b1, 4'd13, "R11 preempting request");
        bus_we = 1'b1; bus_addr = 4'd8; bus_wdata = 8'h00; irq_ack = 1'b1;
        step();
        bus_we = 1'b0; irq_ack = 1'b0;
        pulse(2);
        irq_check(1'b0, 4'd0, "R11 level 8 in service");
        wr(4'd8, 8'h00);
        irq_check(1'b1, 4'd2, "R11 old level 3 was released");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_packing();
        t_masked_and_level();
        t_tie();
        t_stray_ack();
        t_preempt();
        t_single();
        t_hold();
        t_collide();
        t_ret_ack();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule